// File: doc/BRIEF.md
# Grouped Interrupt Cause and Mask Unit

This block collects interrupt sources in groups of `SRC_W` bits, 32 by default. Each group holds three register arrays: a sticky cause vector, a mask vector and an abort-select vector. Source pulses latch into the cause bits. Software can clear causes, inject causes, mask sources, unmask sources and choose the abort sources through a single 32-bit register write port. The write port has a group select and a register select. Set-only and clear-only aliases let software change single bits without a read-modify-write sequence.

The unit sends two outputs per group to the next stage. The interrupt line is high when some cause bit is pending and unmasked. The abort line is high when some cause bit is selected for the DMA abort path. The unit does no moderation and builds no message. A group index that is legal on the bus but not built in this instance reads as zero, and writes to it are ignored.

Top module: `irq_group_agg`

## Requirements
- R1: After reset every cause bit is 0, every mask bit is 1, every abort-select bit is 0, and all `irq_o` and `abort_o` lines are low.
- R2: A 1 on source bit `i` of group `g` in a cycle sets cause bit `i` of group `g` at that clock edge. The bit stays set after the pulse ends.
- R3: A write with select 0 (cause) clears each cause bit whose data bit is 0. Cause bits whose data bit is 1 keep their value.
- R4: A write with select 1 (cause-set alias) sets each cause bit whose data bit is 1. Data bits of 0 have no effect.
- R5: When a source pulse and a select-0 write of 0 hit the same bit in the same cycle, the bit ends set.
- R6: A write with select 2 (mask) loads the mask with the write data. A mask bit of 1 blocks its source from `irq_o`.
- R7: A write with select 3 (mask-clear alias) clears each mask bit whose data bit is 0. Data bits of 1 have no effect.
- R8: A write with select 4 (abort select) loads the abort-select vector with the write data.
- R9: `irq_o[g]` is high exactly when group `g` has at least one cause bit that is 1 and whose mask bit is 0. It follows the registers in the cycle after the edge that updates them.
- R10: `abort_o[g]` is high exactly when group `g` has at least one cause bit that is 1 and whose abort-select bit is 1.
- R11: A write with a group index at or above `NUM_GRP`, or with a select of 5 to 7, changes no state. A read of either kind returns 0.
- R12: The read data is combinational from the group and select inputs. Selects 0 and 1 return the cause vector, selects 2 and 3 return the mask, and select 4 returns the abort-select vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_GRP*SRC_W | Source pulses, group g in bits [g*SRC_W +: SRC_W] |
| reg_we | input | 1 | Write strobe |
| reg_grp | input | $clog2(GRP_MAX) | Group index for reads and writes |
| reg_sel | input | 3 | Register select (0 cause, 1 cause set, 2 mask, 3 mask clear, 4 abort select) |
| reg_wdata | input | SRC_W | Write data |
| reg_rdata | output | SRC_W | Read data for the selected group and register |
| irq_o | output | NUM_GRP | Per-group pending-and-unmasked interrupt |
| abort_o | output | NUM_GRP | Per-group DMA abort request |

## Verification
A corrupted cause, mask or abort-select bit reaches the ports two ways. It shows on `reg_rdata` as soon as that group and select are addressed, with no extra cycle. It also shows on `irq_o` or `abort_o` one cycle after the edge that set it, but only when the other vector lets the bit through. The bench therefore reads every register of every group after each operation and compares both output lines against a model. A decode error that writes the wrong group or alias is caught the next time all registers are read. The error cannot hide behind a masked line, because the readback does not depend on the mask.

// File: rtl/irq_group_pkg.sv
package irq_group_pkg;
   typedef enum logic [2:0] {
      SEL_CAUSE = 3'd0,
      SEL_CSET  = 3'd1,
      SEL_MASK  = 3'd2,
      SEL_MCLR  = 3'd3,
      SEL_ABORT = 3'd4
   } reg_sel_e;

   typedef struct packed {
      logic cause_clr;
      logic cause_set;
      logic mask_ld;
      logic mask_clr;
      logic abort_ld;
   } grp_wstrb_t;
endpackage

// File: rtl/irq_group_dec.sv
module irq_group_dec
   import irq_group_pkg::*;
#(
   parameter int NUM_GRP = 2,
   parameter int GSW     = 3
) (
   input  logic                reg_we,
   input  logic [GSW-1:0]      reg_grp,
   input  logic [2:0]          reg_sel,
   output grp_wstrb_t          strb [NUM_GRP]
);
   for (genvar g = 0; g < NUM_GRP; g++) begin : g_dec
      logic hit;
      assign hit = reg_we && (reg_grp == GSW'(g));
      always_comb begin
         strb[g] = '0;
         if (hit) begin
            unique case (reg_sel)
               SEL_CAUSE: strb[g].cause_clr = 1'b1;
               SEL_CSET:  strb[g].cause_set = 1'b1;
               SEL_MASK:  strb[g].mask_ld   = 1'b1;
               SEL_MCLR:  strb[g].mask_clr  = 1'b1;
               SEL_ABORT: strb[g].abort_ld  = 1'b1;
               default:   strb[g] = '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/irq_group_bank.sv
module irq_group_bank
   import irq_group_pkg::*;
#(
   parameter int SRC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] src,
   input  grp_wstrb_t       strb,
   input  logic [SRC_W-1:0] wdata,
   output logic [SRC_W-1:0] cause,
   output logic [SRC_W-1:0] mask,
   output logic [SRC_W-1:0] abmask
);
   logic [SRC_W-1:0] cause_d, mask_d, abmask_d;

   always_comb begin
      // software effect first, hardware sources ORed last so they win
      cause_d = strb.cause_clr ? (cause & wdata) : cause;
      if (strb.cause_set) cause_d = cause_d | wdata;
      cause_d = cause_d | src;

      mask_d = mask;
      if (strb.mask_ld)       mask_d = wdata;
      else if (strb.mask_clr) mask_d = mask & wdata;

      abmask_d = strb.abort_ld ? wdata : abmask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause  <= '0;
         mask   <= '1;
         abmask <= '0;
      end else begin
         cause  <= cause_d;
         mask   <= mask_d;
         abmask <= abmask_d;
      end
   end
endmodule

// File: rtl/irq_group_reduce.sv
module irq_group_reduce #(
   parameter int SRC_W   = 32,
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] cause,
   input  logic [SRC_W-1:0] mask,
   input  logic [SRC_W-1:0] abmask,
   output logic             irq,
   output logic             abort
);
   logic irq_c, abort_c;
   assign irq_c   = |(cause & ~mask);
   assign abort_c = |(cause & abmask);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq   <= 1'b0;
            abort <= 1'b0;
         end else begin
            irq   <= irq_c;
            abort <= abort_c;
         end
      end
   end else begin : g_comb
      assign irq   = irq_c;
      assign abort = abort_c;
   end
endmodule

// File: rtl/irq_group_agg.sv
module irq_group_agg
   import irq_group_pkg::*;
#(
   parameter int NUM_GRP = 2,
   parameter int GRP_MAX = 8,
   parameter int SRC_W   = 32,
   parameter bit REG_OUT = 1'b0,
   localparam int GSW    = (GRP_MAX > 1) ? $clog2(GRP_MAX) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_GRP*SRC_W-1:0] src_i,
   input  logic                     reg_we,
   input  logic [GSW-1:0]           reg_grp,
   input  logic [2:0]               reg_sel,
   input  logic [SRC_W-1:0]         reg_wdata,
   output logic [SRC_W-1:0]         reg_rdata,
   output logic [NUM_GRP-1:0]       irq_o,
   output logic [NUM_GRP-1:0]       abort_o
);
   if (NUM_GRP < 1 || NUM_GRP > GRP_MAX) begin : g_bad_grp
      $error("NUM_GRP must lie in 1..GRP_MAX");
   end
   if (SRC_W < 1 || SRC_W > 32) begin : g_bad_w
      $error("SRC_W must lie in 1..32");
   end

   grp_wstrb_t       strb   [NUM_GRP];
   logic [SRC_W-1:0] cause  [NUM_GRP];
   logic [SRC_W-1:0] mask   [NUM_GRP];
   logic [SRC_W-1:0] abmask [NUM_GRP];
   logic [NUM_GRP*SRC_W-1:0] cause_all, mask_all, abmask_all;

   irq_group_dec #(.NUM_GRP(NUM_GRP), .GSW(GSW)) u_dec (
      .reg_we (reg_we),
      .reg_grp(reg_grp),
      .reg_sel(reg_sel),
      .strb   (strb)
   );

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      irq_group_bank #(.SRC_W(SRC_W)) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .src   (src_i[g*SRC_W +: SRC_W]),
         .strb  (strb[g]),
         .wdata (reg_wdata),
         .cause (cause[g]),
         .mask  (mask[g]),
         .abmask(abmask[g])
      );
      irq_group_reduce #(.SRC_W(SRC_W), .REG_OUT(REG_OUT)) u_red (
         .clk   (clk),
         .rst_n (rst_n),
         .cause (cause[g]),
         .mask  (mask[g]),
         .abmask(abmask[g]),
         .irq   (irq_o[g]),
         .abort (abort_o[g])
      );
      assign cause_all [g*SRC_W +: SRC_W] = cause[g];
      assign mask_all  [g*SRC_W +: SRC_W] = mask[g];
      assign abmask_all[g*SRC_W +: SRC_W] = abmask[g];
   end

   always_comb begin
      reg_rdata = '0;
      for (int g = 0; g < NUM_GRP; g++) begin
         if (reg_grp == GSW'(g)) begin
            case (reg_sel)
               SEL_CAUSE, SEL_CSET: reg_rdata = cause[g];
               SEL_MASK,  SEL_MCLR: reg_rdata = mask[g];
               SEL_ABORT:           reg_rdata = abmask[g];
               default:             reg_rdata = '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/irq_group_agg_chk.sv
module irq_group_agg_chk #(
   parameter int NUM_GRP = 2,
   parameter int SRC_W   = 32,
   parameter int GSW     = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_GRP*SRC_W-1:0] src_i,
   input logic                     reg_we,
   input logic [GSW-1:0]           reg_grp,
   input logic [2:0]               reg_sel,
   input logic [SRC_W-1:0]         reg_wdata,
   input logic [NUM_GRP-1:0]       irq_o,
   input logic [NUM_GRP*SRC_W-1:0] cause_all,
   input logic [NUM_GRP*SRC_W-1:0] mask_all,
   input logic [NUM_GRP*SRC_W-1:0] abmask_all
);
   // R2
   src_sets_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_i != '0) |=> ((cause_all & $past(src_i)) == $past(src_i)));

   // R11
   bad_grp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && int'(reg_grp) >= NUM_GRP && src_i == '0)
      |=> ($stable(cause_all) && $stable(mask_all) && $stable(abmask_all)));

   // R7
   mclr_ones_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel == 3'd3 && reg_wdata == '1) |=> $stable(mask_all));

   // R3
   cause_ones_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel == 3'd0 && reg_wdata == '1)
      |=> ((cause_all & $past(cause_all)) == $past(cause_all)));

   // R9
   full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_all == '1) |-> (irq_o == '0));
endmodule

bind irq_group_agg irq_group_agg_chk #(.NUM_GRP(NUM_GRP), .SRC_W(SRC_W), .GSW(GSW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_i     (src_i),
   .reg_we    (reg_we),
   .reg_grp   (reg_grp),
   .reg_sel   (reg_sel),
   .reg_wdata (reg_wdata),
   .irq_o     (irq_o),
   .cause_all (cause_all),
   .mask_all  (mask_all),
   .abmask_all(abmask_all)
);

// File: tb/sim_irq_group_agg.sv
`timescale 1ns/100ps
module sim_irq_group_agg;
   localparam int NG  = 2;
   localparam int W   = 32;
   localparam int GSW = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NG*W-1:0] src_i = '0;
   logic            reg_we = 1'b0;
   logic [GSW-1:0]  reg_grp = '0;
   logic [2:0]      reg_sel = '0;
   logic [W-1:0]    reg_wdata = '0;
   logic [W-1:0]    reg_rdata;
   logic [NG-1:0]   irq_o, abort_o;

   logic [W-1:0] m_cause [NG];
   logic [W-1:0] m_mask  [NG];
   logic [W-1:0] m_ab    [NG];
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   irq_group_agg #(.NUM_GRP(NG), .GRP_MAX(8), .SRC_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_we(reg_we),
      .reg_grp(reg_grp), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_o(irq_o), .abort_o(abort_o)
   );

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one clock cycle with optional write and source pulses; model updated per R2..R8, R11
   task automatic cyc(bit we, int g, int sel, logic [W-1:0] d, logic [NG*W-1:0] s);
      @(negedge clk);
      reg_we = we; reg_grp = GSW'(g); reg_sel = 3'(sel); reg_wdata = d; src_i = s;
      @(posedge clk);
      #1;
      reg_we = 1'b0; src_i = '0;
      if (we && g < NG) begin
         case (sel)
            0: m_cause[g] = m_cause[g] & d;
            1: m_cause[g] = m_cause[g] | d;
            2: m_mask[g]  = d;
            3: m_mask[g]  = m_mask[g] & d;
            4: m_ab[g]    = d;
            default: ;
         endcase
      end
      for (int k = 0; k < NG; k++) m_cause[k] = m_cause[k] | s[k*W +: W];
   endtask

   task automatic compare_all(string req);
      for (int g = 0; g < NG; g++) begin
         for (int sel = 0; sel < 8; sel++) begin
            logic [W-1:0] e;
            reg_grp = GSW'(g); reg_sel = 3'(sel);
            #0.2;
            e = (sel < 2) ? m_cause[g] : (sel < 4) ? m_mask[g] : (sel == 4) ? m_ab[g] : '0;
            chk({req, " R12 readback"}, reg_rdata, e);
         end
         chk({req, " R9 irq"}, W'(irq_o[g]), W'(|(m_cause[g] & ~m_mask[g])));
         chk({req, " R10 abort"}, W'(abort_o[g]), W'(|(m_cause[g] & m_ab[g])));
      end
      for (int g = NG; g < 8; g++) begin
         reg_grp = GSW'(g); reg_sel = 3'd0;
         #0.2;
         chk("R11 absent group read", reg_rdata, '0);
      end
   endtask

   initial begin
      for (int g = 0; g < NG; g++) begin
         m_cause[g] = '0; m_mask[g] = '1; m_ab[g] = '0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      compare_all("R1 reset");

      // R2: walking source bit in each group
      for (int g = 0; g < NG; g++)
         for (int i = 0; i < W; i++) begin
            cyc(0, 0, 0, '0, (NG*W)'(1) << (g*W + i));
            chk("R2 source latch", m_cause[g], 32'hFFFF_FFFF >> (W-1-i));
            compare_all("R2");
         end
      // R3: walking zero clear in group 0
      for (int i = 0; i < W; i += 3) begin
         cyc(1, 0, 0, ~(32'd1 << i), '0);
         compare_all("R3");
      end
      cyc(1, 1, 0, 32'hFFFF_FFFF, '0); compare_all("R3 ones keep");
      cyc(1, 1, 0, 32'h0, '0);         compare_all("R3 clear all");
      // R4: set alias patterns
      cyc(1, 1, 1, 32'hA5A5_0000, '0); compare_all("R4");
      cyc(1, 1, 1, 32'h0, '0);         compare_all("R4 zeros");
      cyc(1, 0, 1, 32'h0000_00F0, '0); compare_all("R4 g0");
      // R5: clear-all write collides with source bit 5 of group 0
      cyc(1, 0, 0, 32'h0, (NG*W)'(32'h20));
      chk("R5 set wins", m_cause[0], 32'h20);
      compare_all("R5");
      // R6/R7: mask load and mask-clear alias sweeps; R9 irq follows
      cyc(1, 0, 2, 32'hFFFF_FFDF, '0); compare_all("R6 unmask bit5");
      cyc(1, 0, 2, 32'hFFFF_FFFF, '0); compare_all("R6 mask all");
      for (int i = 0; i < W; i += 5) begin
         cyc(1, 1, 3, ~(32'd1 << i), '0);
         compare_all("R7");
      end
      cyc(1, 1, 3, 32'hFFFF_FFFF, '0); compare_all("R7 ones noop");
      // R8/R10: abort select
      cyc(1, 0, 4, 32'h0000_0080, '0); compare_all("R8 no hit");
      cyc(1, 0, 4, 32'h0000_0020, '0); compare_all("R8 hit");
      cyc(1, 1, 4, 32'h00A5_0000, '0); compare_all("R10 g1");
      // R11: absent groups and unused selects
      for (int g = NG; g < 8; g++)
         for (int sel = 0; sel < 5; sel++) begin
            cyc(1, g, sel, (sel == 1) ? 32'hFFFF_FFFF : 32'h0, '0);
            compare_all("R11 absent group write");
         end
      for (int sel = 5; sel < 8; sel++) begin
         cyc(1, 0, sel, 32'h0, '0);
         compare_all("R11 unused select");
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule